// File: doc/BRIEF.md
# Warp spawn allocator

When a running warp issues a spawn, this block picks a slot for the new warp from a table of warp slots. It looks for the lowest-numbered slot that has not yet been started and claims it. It then issues the commands that seed that warp. The new warp gets a start program counter, exactly one active thread and user privilege. Its thread 0 has one register preloaded with a value supplied by the spawning warp.

The block keeps only the per-slot "started" flags. The warp state it initialises (program counter table, register file, thread count, privilege bit) lives outside and is driven by a registered write command. That command is valid for the single cycle after the request. The scheduler owns the request pulse: one pulse per spawn instruction, regardless of how many threads of the issuing warp are active.

When every slot is already started, a request leaves the table unchanged and raises a one-cycle no-slot flag instead. After reset, slot 0 counts as the running warp and all other slots are free.

Top module: `wsa_spawn_alloc`

## Requirements
- R1: During and after reset, `spawned` equals 1 (only bit 0 set), and `init_valid` and `no_slot` are 0.
- R2: A request cycle with at least one clear bit in `spawned` yields, one clock later, `init_valid`=1 and `init_slot` equal to the index of the lowest clear bit.
- R3: In that write cycle, `init_pc` equals the `spawn_pc` of the request.
- R4: In that write cycle, `init_rd` and `init_data` equal the `spawn_rd` and `spawn_data` of the request; this is the register write for thread 0 of the new warp.
- R5: In that write cycle, `init_threads` equals 1 and `init_super` equals 0 (user mode).
- R6: After a granted request, bit `init_slot` of `spawned` is set and every other bit is unchanged.
- R7: A request made while all bits of `spawned` are set yields, one clock later, `no_slot`=1 and `init_valid`=0, with `spawned` unchanged.
- R8: A cycle without a request yields `init_valid`=0 and `no_slot`=0 one clock later, with `spawned` unchanged.
- R9: Each request cycle is one spawn. A request held for N consecutive cycles claims N successive slots, until no slot is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spawn_req | input | 1 | One spawn per cycle it is high |
| spawn_pc | input | PC_W | Start program counter for the new warp |
| spawn_data | input | DATA_W | Value to preload into the new warp's thread 0 |
| spawn_rd | input | RIDX_W | Destination register index for that value |
| init_valid | output | 1 | Initialisation write command valid |
| init_slot | output | $clog2(NUM_SLOTS) | Slot being initialised |
| init_pc | output | PC_W | Program counter to store for that slot |
| init_rd | output | RIDX_W | Thread 0 register index to write |
| init_data | output | DATA_W | Thread 0 register value to write |
| init_threads | output | $clog2(MAX_THREADS+1) | Active thread count for the slot (always 1) |
| init_super | output | 1 | Supervisor bit for the slot (always 0) |
| spawned | output | NUM_SLOTS | Per-slot started flags |
| no_slot | output | 1 | Previous request found no free slot |

## Verification
The bench exercises requests with gaps between them, which shows that each grant reads the updated flags. It also holds the request high for several cycles, which shows that every request cycle claims exactly one new slot.

Requests continue past the point where the table is full, which separates the no-slot path from a grant. A reset in the middle of a sequence shows that slots are freed back to the reset pattern.

Operand values vary per round: walking, inverted, all-ones and mixed patterns in the program counter, data and register index. These patterns expose a swapped, truncated or stale field in the write command.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  typedef enum logic {MODE_USER = 1'b0, MODE_SUPER = 1'b1} wsa_mode_e;
  localparam int unsigned WSA_INIT_THREADS = 1;
  localparam wsa_mode_e   WSA_INIT_MODE    = MODE_USER;
endpackage

// File: rtl/wsa_first_free.sv
module wsa_first_free #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  free_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = free_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | free_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) idx_o = idx_o | IW'(i);
  end

  always_comb begin
    assert_grant_onehot_R2: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/wsa_slot_flags.sv
module wsa_slot_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o
);
  localparam logic [N-1:0] RESET_MASK = N'(1);

  always_ff @(posedge clk) begin
    if (rst) flags_o <= RESET_MASK;
    else     flags_o <= flags_o | set_i;
  end

  assert_set_only_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(flags_o) & ~flags_o) == '0);
endmodule

// File: rtl/wsa_write_stage.sv
module wsa_write_stage #(
  parameter int unsigned IW     = 2,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              any_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [RIDX_W-1:0] rd_i,
  output logic              valid_o,
  output logic              none_o,
  output logic [IW-1:0]     slot_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [DATA_W-1:0] data_o,
  output logic [RIDX_W-1:0] rd_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      none_o  <= 1'b0;
    end else begin
      valid_o <= req_i & any_i;
      none_o  <= req_i & ~any_i;
    end
  end

  always_ff @(posedge clk) begin
    if (req_i & any_i) begin
      slot_o <= idx_i;
      pc_o   <= pc_i;
      data_o <= data_i;
      rd_o   <= rd_i;
    end
  end

  assert_valid_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && none_o));
endmodule

// File: rtl/wsa_spawn_alloc.sv
module wsa_spawn_alloc #(
  parameter int unsigned NUM_SLOTS   = 4,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned RIDX_W      = 5,
  parameter int unsigned MAX_THREADS = 4,
  localparam int unsigned SIDX_W = $clog2(NUM_SLOTS),
  localparam int unsigned TCNT_W = $clog2(MAX_THREADS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spawn_req,
  input  logic [PC_W-1:0]   spawn_pc,
  input  logic [DATA_W-1:0] spawn_data,
  input  logic [RIDX_W-1:0] spawn_rd,
  output logic              init_valid,
  output logic [SIDX_W-1:0] init_slot,
  output logic [PC_W-1:0]   init_pc,
  output logic [RIDX_W-1:0] init_rd,
  output logic [DATA_W-1:0] init_data,
  output logic [TCNT_W-1:0] init_threads,
  output logic              init_super,
  output logic [NUM_SLOTS-1:0] spawned,
  output logic              no_slot
);
  import wsa_pkg::*;

  logic [NUM_SLOTS-1:0] grant;
  logic [SIDX_W-1:0]    grant_idx;
  logic                 grant_any;
  logic [NUM_SLOTS-1:0] set_mask;

  wsa_first_free #(.N(NUM_SLOTS)) u_find (
    .free_i  (~spawned),
    .grant_o (grant),
    .idx_o   (grant_idx),
    .any_o   (grant_any)
  );

  assign set_mask = spawn_req ? grant : '0;

  wsa_slot_flags #(.N(NUM_SLOTS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_mask),
    .flags_o (spawned)
  );

  wsa_write_stage #(
    .IW(SIDX_W), .PC_W(PC_W), .DATA_W(DATA_W), .RIDX_W(RIDX_W)
  ) u_wr (
    .clk     (clk),
    .rst     (rst),
    .req_i   (spawn_req),
    .any_i   (grant_any),
    .idx_i   (grant_idx),
    .pc_i    (spawn_pc),
    .data_i  (spawn_data),
    .rd_i    (spawn_rd),
    .valid_o (init_valid),
    .none_o  (no_slot),
    .slot_o  (init_slot),
    .pc_o    (init_pc),
    .data_o  (init_data),
    .rd_o    (init_rd)
  );

  assign init_threads = TCNT_W'(WSA_INIT_THREADS);
  assign init_super   = WSA_INIT_MODE;

  assert_lowest_free_R2: assert property (@(posedge clk) disable iff (rst)
    init_valid |-> ((((~$past(spawned)) >> init_slot) & NUM_SLOTS'(1)) == NUM_SLOTS'(1)) &&
                   (((~$past(spawned)) & ((NUM_SLOTS'(1) << init_slot) - NUM_SLOTS'(1))) == '0));

  assert_one_claim_R9: assert property (@(posedge clk) disable iff (rst)
    (spawn_req && !(&spawned)) |=> ($countones(spawned) == $past($countones(spawned)) + 1) && init_valid);

  assert_full_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (spawn_req && (&spawned)) |=> $stable(spawned) && no_slot && !init_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !spawn_req |=> $stable(spawned) && !no_slot && !init_valid);

  assert_seed_fields_R3: assert property (@(posedge clk) disable iff (rst)
    (spawn_req && !(&spawned)) |=> init_pc == $past(spawn_pc) && init_data == $past(spawn_data)
                                  && init_rd == $past(spawn_rd));
endmodule

// File: tb/tb_wsa_spawn_alloc.sv
module tb_wsa_spawn_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int PW = 32;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int SW = $clog2(NS);
  localparam int TW = $clog2(4 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spawn_req = 1'b0;
  logic [PW-1:0] spawn_pc = '0;
  logic [DW-1:0] spawn_data = '0;
  logic [RW-1:0] spawn_rd = '0;
  logic init_valid, init_super, no_slot;
  logic [SW-1:0] init_slot;
  logic [PW-1:0] init_pc;
  logic [RW-1:0] init_rd;
  logic [DW-1:0] init_data;
  logic [TW-1:0] init_threads;
  logic [NS-1:0] spawned;

  int errors = 0;
  int checks = 0;
  logic [NS-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsa_spawn_alloc #(.NUM_SLOTS(NS), .PC_W(PW), .DATA_W(DW), .RIDX_W(RW), .MAX_THREADS(4)) dut (
    .clk(clk), .rst(rst), .spawn_req(spawn_req), .spawn_pc(spawn_pc),
    .spawn_data(spawn_data), .spawn_rd(spawn_rd), .init_valid(init_valid),
    .init_slot(init_slot), .init_pc(init_pc), .init_rd(init_rd),
    .init_data(init_data), .init_threads(init_threads), .init_super(init_super),
    .spawned(spawned), .no_slot(no_slot));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; spawn_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(spawned == NS'(1), "R1 spawned in reset", spawned, 1);
    rst = 1'b0;
    model = NS'(1);
    @(negedge clk);
    chk(spawned == NS'(1), "R1 spawned after reset", spawned, 1);
    chk(!init_valid, "R1 init_valid", init_valid, 0);
    chk(!no_slot, "R1 no_slot", no_slot, 0);
  endtask

  // Drives one cycle at a negedge, checks the registered result at the next negedge.
  task automatic step(input bit req, input logic [PW-1:0] pc, input logic [DW-1:0] d,
                      input logic [RW-1:0] rd);
    int exp_slot;
    bit full;
    spawn_req = req; spawn_pc = pc; spawn_data = d; spawn_rd = rd;
    exp_slot = -1;
    for (int i = NS-1; i >= 0; i--) if (!model[i]) exp_slot = i;
    full = (exp_slot < 0);
    @(negedge clk);
    if (req && !full) begin
      chk(init_valid == 1'b1, "R2 valid", init_valid, 1);
      chk(int'(init_slot) == exp_slot, "R2 slot", init_slot, exp_slot);
      chk(init_pc == pc, "R3 pc", init_pc, pc);
      chk(init_rd == rd, "R4 rd", init_rd, rd);
      chk(init_data == d, "R4 data", init_data, d);
      chk(init_threads == TW'(1), "R5 threads", init_threads, 1);
      chk(init_super == 1'b0, "R5 super", init_super, 0);
      chk(!no_slot, "R2 no_slot low", no_slot, 0);
      model[exp_slot] = 1'b1;
      chk(spawned == model, "R6 flags", spawned, model);
    end else if (req) begin
      chk(no_slot == 1'b1, "R7 no_slot", no_slot, 1);
      chk(!init_valid, "R7 valid low", init_valid, 0);
      chk(spawned == model, "R7 flags stable", spawned, model);
    end else begin
      chk(!init_valid && !no_slot, "R8 quiet", {init_valid, no_slot}, 0);
      chk(spawned == model, "R8 flags stable", spawned, model);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 6; r++) begin
      do_reset();
      step(1'b0, '0, '0, '0);
      for (int k = 0; k < NS + 2; k++) begin
        logic [PW-1:0] pc;
        logic [DW-1:0] d;
        pc = PW'(32'h1000 * (r + 1) + 4 * k);
        case (r % 3)
          0: d = DW'(1) << (k + r);
          1: d = ~(DW'(1) << (k * 5));
          default: d = (k % 2 == 0) ? '1 : DW'(32'hA5A5_5A5A ^ k);
        endcase
        if (r == 5) pc = ~pc;
        // R9: odd rounds hold the request high back-to-back
        step(1'b1, pc, d, RW'(r * 7 + k * 3 + 31));
        if (r % 2 == 0) step(1'b0, '1, '1, '1);
      end
      step(1'b0, '0, '0, '0);
    end
    // R1: reset in the middle of a sequence frees slots again
    do_reset();
    step(1'b1, 32'hDEAD_0000, 32'h1, 5'd1);
    step(1'b1, 32'hDEAD_0004, 32'h2, 5'd2);
    do_reset();
    step(1'b1, 32'hBEEF_0000, 32'h3, 5'd3);
    chk(init_slot == SW'(1), "R1 R2 first slot after reset", init_slot, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule